// File: doc/BRIEF.md
# Bilinear Charge-to-Code Digitizer

This block is the digital back end of one charge-digitizing channel. Upstream logic turns the integrated input charge into a train of unit pulses. Each pulse is worth a quarter of a picocoulomb. The pulses arrive on one input, one per clock cycle at most, between a start strobe and an end-of-charge strobe. The block counts those pulses into an 8-bit output code. A 3-bit mode selects how pulses map to codes.

The two linear settings use either one pulse per code step or four pulses per code step. The three bilinear settings count at fine resolution until the code reaches a breakpoint of 32, 64 or 128. Past that point they step once per four pulses. This keeps fine resolution for small signals while stretching full scale. The all-ones code marks a reading that is off scale.

A conversion runs in three stages. A start strobe clears the channel and arms it. Pulses accumulate while the channel is armed. The end-of-charge strobe freezes the result and raises a done flag that stays high until the next start.

Top module: `bilin_digitizer`

## Requirements
- R1: After a cycle with `start_i` high, `code_o` is 0 and `done_o` is 0 and the channel is armed. `start_i` takes priority over `pulse_i` and `eoc_i` in the same cycle, so a pulse presented with start is not counted.
- R2: `mode_i` is captured on the start cycle. Code 0 is fine linear: one code step per pulse. Code 1 is coarse linear: one code step per four pulses.
- R3: Codes 2, 3 and 4 are bilinear, with breakpoints 32, 64 and 128. Below the breakpoint every pulse adds one to the code. Once the code equals or exceeds the breakpoint, exactly every fourth pulse adds one.
- R4: The code saturates at 255 and never wraps. `ovf_o` is high exactly when `code_o` is 255.
- R5: Mode codes 5, 6 and 7 behave as fine linear mode.
- R6: `done_o` goes high in the cycle after the one in which `eoc_i` is sampled while armed, and stays high until the next start. Pulses arriving while the channel is not armed leave `code_o` unchanged.
- R7: A pulse presented in the same cycle as the end-of-charge strobe is still counted.
- R8: Changing `mode_i` during a conversion has no effect on that conversion.
- R9: After reset, `code_o` is 0 and `done_o` and `ovf_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe: clears and arms the channel |
| pulse_i | input | 1 | One unit charge pulse (0.25 pC) this cycle |
| eoc_i | input | 1 | End-of-charge strobe |
| mode_i | input | 3 | Conversion mode select |
| code_o | output | 8 | Output code |
| done_o | output | 1 | Conversion finished, result valid |
| ovf_o | output | 1 | Code is at the off-scale value 255 |

## Verification
A wrong prescaler phase or a stale breakpoint only shows at the ports a few pulses past the breakpoint. That is within four counted pulses of the code reaching it. The error then appears as a code that is off by one or more. For this reason the vectors place pulse totals on both sides of each breakpoint and of every fourth-pulse step. A broken saturation shows as a small code where 255 is expected, as soon as the count passes full scale. A control fault shows one cycle after the strobe, as a missing or early done flag or as a code that moves after completion.

// File: rtl/bdig_pkg.sv
package bdig_pkg;

   // conversion sequencing
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_DONE   = 2'd2
   } seq_state_t;

   // mode select encodings
   localparam int unsigned MODE_FINE     = 0;
   localparam int unsigned MODE_COARSE   = 1;
   localparam int unsigned MODE_BILIN_LO = 2;
   localparam int unsigned MODE_BILIN_MD = 3;
   localparam int unsigned MODE_BILIN_HI = 4;
   localparam int unsigned NUM_BILIN     = 3;

endpackage

// File: rtl/bdig_mode_latch.sv
module bdig_mode_latch
   import bdig_pkg::*;
#(
   parameter int unsigned MODE_W = 3,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned BP_LO  = 32,
   parameter int unsigned BP_MD  = 64,
   parameter int unsigned BP_HI  = 128,
   localparam int unsigned BP_W  = CODE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [MODE_W-1:0] mode,
   output logic [BP_W-1:0]   bp_q
);

   localparam logic [BP_W-1:0] BP_FINE   = BP_W'(1) << CODE_W;
   localparam logic [BP_W-1:0] BP_COARSE = '0;

   logic [NUM_BILIN-1:0]  hit;
   logic [BP_W-1:0]       hit_bp [NUM_BILIN];
   logic [BP_W-1:0]       bp_d;

   // one comparator per bilinear setting
   for (genvar g = 0; g < NUM_BILIN; g++) begin : g_bilin
      localparam int unsigned THIS_BP   = (g == 0) ? BP_LO : (g == 1) ? BP_MD : BP_HI;
      localparam int unsigned THIS_MODE = MODE_BILIN_LO + g;
      assign hit[g]    = (mode == MODE_W'(THIS_MODE));
      assign hit_bp[g] = hit[g] ? BP_W'(THIS_BP) : '0;
   end

   always_comb begin
      bp_d = '0;
      for (int i = 0; i < NUM_BILIN; i++) bp_d = bp_d | hit_bp[i];
      if (mode == MODE_W'(MODE_COARSE))
         bp_d = BP_COARSE;
      else if (hit == '0)
         bp_d = BP_FINE;          // fine linear and every undefined code
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bp_q <= BP_FINE;
      else if (load)
         bp_q <= bp_d;
   end

   AST_BP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(bp_q)); // R8

   AST_BP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> (bp_q == BP_FINE || bp_q == BP_COARSE || bp_q == BP_W'(BP_LO)
                      || bp_q == BP_W'(BP_MD) || bp_q == BP_W'(BP_HI))); // R2

endmodule

// File: rtl/bdig_prescaler.sv
module bdig_prescaler #(
   parameter int unsigned PRESC_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);

   logic [PRESC_W-1:0] cnt_q;

   assign tick = en && (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (en)
         cnt_q <= cnt_q + 1'b1;
   end

   AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(cnt_q)); // R3

   AST_PRESC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/bdig_code_ctr.sv
module bdig_code_ctr #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [CODE_W-1:0] code_q,
   output logic              sat
);

   assign sat = (code_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= '0;
      else if (clr)
         code_q <= '0;
      else if (inc && !sat)
         code_q <= code_q + 1'b1;
   end

   AST_CODE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !clr) |=> (code_q == '1)); // R4

   AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1)); // R3

endmodule

// File: rtl/bilin_digitizer.sv
module bilin_digitizer
   import bdig_pkg::*;
#(
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned MODE_W  = 3,
   parameter int unsigned PRESC_W = 2,
   parameter int unsigned BP_LO   = 32,
   parameter int unsigned BP_MD   = 64,
   parameter int unsigned BP_HI   = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              pulse_i,
   input  logic              eoc_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [CODE_W-1:0] code_o,
   output logic              done_o,
   output logic              ovf_o
);

   localparam int unsigned BP_W     = CODE_W + 1;
   localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

   // elaboration-time parameter checks
   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
      $error("CODE_W out of range");
   end
   if (MODE_W < 3) begin : g_bad_mode_w
      $error("MODE_W must hold five modes");
   end
   if (PRESC_W < 1) begin : g_bad_presc
      $error("PRESC_W must be at least 1");
   end
   if (!(BP_LO > 0 && BP_LO < BP_MD && BP_MD < BP_HI && BP_HI < CODE_MAX)) begin : g_bad_bp
      $error("breakpoints must be strictly increasing inside the code range");
   end

   seq_state_t          st_q;
   logic [BP_W-1:0]     bp_q;
   logic [CODE_W-1:0]   code_q;
   logic                sat;
   logic                coarse;
   logic                step;
   logic                tick;
   logic                inc;

   // sequencing: start wins over everything, eoc only ends an armed run
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_IDLE;
      else if (start_i)
         st_q <= ST_ARMED;
      else if (st_q == ST_ARMED && eoc_i)
         st_q <= ST_DONE;
   end

   bdig_mode_latch #(
      .MODE_W (MODE_W),
      .CODE_W (CODE_W),
      .BP_LO  (BP_LO),
      .BP_MD  (BP_MD),
      .BP_HI  (BP_HI)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_i),
      .mode  (mode_i),
      .bp_q  (bp_q)
   );

   assign coarse = ({1'b0, code_q} >= bp_q);
   assign step   = (st_q == ST_ARMED) && pulse_i && !start_i && !sat;
   assign inc    = step && (coarse ? tick : 1'b1);

   bdig_prescaler #(
      .PRESC_W (PRESC_W)
   ) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_i),
      .en    (step && coarse),
      .tick  (tick)
   );

   bdig_code_ctr #(
      .CODE_W (CODE_W)
   ) u_code (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (start_i),
      .inc    (inc),
      .code_q (code_q),
      .sat    (sat)
   );

   assign code_o = code_q;
   assign done_o = (st_q == ST_DONE);
   assign ovf_o  = sat;

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (code_o == '0 && !done_o)); // R1

   AST_DONE_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ARMED && eoc_i && !start_i) |=> done_o); // R6

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_ARMED && !start_i) |=> ($stable(code_o) && $stable(done_o))); // R6

   AST_FINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ARMED && pulse_i && !start_i && !coarse && !sat)
         |=> (code_o == $past(code_o) + 1'b1)); // R3

endmodule

// File: tb/tb_bilin_digitizer.sv
module tb_bilin_digitizer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       pulse_i = 1'b0;
   logic       eoc_i = 1'b0;
   logic [2:0] mode_i = 3'd0;
   logic [7:0] code_o;
   logic       done_o;
   logic       ovf_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   bilin_digitizer dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .pulse_i (pulse_i),
      .eoc_i   (eoc_i),
      .mode_i  (mode_i),
      .code_o  (code_o),
      .done_o  (done_o),
      .ovf_o   (ovf_o)
   );

   localparam int NV = 18;
   localparam int VEC_MODE [NV] = '{0, 0, 0, 1, 1, 1, 1, 2, 2, 2, 2, 3, 3, 4, 4, 5, 7, 2};
   localparam int VEC_N    [NV] = '{10, 255, 300, 8, 1019, 1020, 1100, 31, 32, 36, 37, 64, 100, 130, 600, 40, 300, 1000};

   // independent model of the requirements
   function automatic int ref_code(int mode, int n);
      int bp;
      int c;
      case (mode)
         1: bp = 0;
         2: bp = 32;
         3: bp = 64;
         4: bp = 128;
         default: bp = 256;
      endcase
      if (n <= bp) c = n;
      else c = bp + (n - bp) / 4;
      if (c > 255) c = 255;
      return c;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_start(int mode, bit with_pulse);
      @(negedge clk);
      start_i = 1'b1;
      pulse_i = with_pulse;
      mode_i  = 3'(mode);
      @(negedge clk);
      start_i = 1'b0;
      pulse_i = 1'b0;
   endtask

   task automatic do_pulses(int n);
      for (int i = 0; i < n; i++) begin
         pulse_i = 1'b1;
         @(negedge clk);
      end
      pulse_i = 1'b0;
   endtask

   task automatic do_eoc(bit with_pulse);
      eoc_i   = 1'b1;
      pulse_i = with_pulse;
      @(negedge clk);
      eoc_i   = 1'b0;
      pulse_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 code", int'(code_o), 0);
      chk("R9 done", int'(done_o), 0);
      chk("R9 ovf", int'(ovf_o), 0);
      rst_n = 1'b1;

      // vector table: R2 R3 R4 R5
      for (int v = 0; v < NV; v++) begin
         int exp;
         exp = ref_code(VEC_MODE[v], VEC_N[v]);
         do_start(VEC_MODE[v], 1'b0);
         do_pulses(VEC_N[v]);
         do_eoc(1'b0);
         chk($sformatf("R2/R3/R5 code mode=%0d n=%0d", VEC_MODE[v], VEC_N[v]), int'(code_o), exp);
         chk("R4 ovf", int'(ovf_o), (exp == 255) ? 1 : 0);
         chk("R6 done", int'(done_o), 1);
      end

      // R6: done timing and pulses after completion ignored
      do_start(0, 1'b0);
      chk("R1 done low after start", int'(done_o), 0);
      do_pulses(5);
      eoc_i = 1'b1;
      chk("R6 done not early", int'(done_o), 0);
      @(negedge clk);
      eoc_i = 1'b0;
      chk("R6 done one cycle after eoc", int'(done_o), 1);
      do_pulses(20);
      chk("R6 code frozen after done", int'(code_o), 5);
      chk("R6 done held", int'(done_o), 1);

      // R1: start clears, pulse with start not counted
      do_start(0, 1'b1);
      chk("R1 code cleared", int'(code_o), 0);
      chk("R1 done cleared", int'(done_o), 0);
      do_pulses(5);
      do_eoc(1'b0);
      chk("R1 pulse with start ignored", int'(code_o), 5);

      // R7: pulse with eoc counted
      do_start(0, 1'b0);
      do_pulses(6);
      do_eoc(1'b1);
      chk("R7 pulse with eoc counted", int'(code_o), 7);

      // R8: mode change mid-run has no effect
      do_start(2, 1'b0);
      do_pulses(10);
      mode_i = 3'd1;
      do_pulses(30);
      do_eoc(1'b0);
      chk("R8 mode latched", int'(code_o), ref_code(2, 40));

      // R1: start overrides a saturated result, restart counts again
      do_start(0, 1'b0);
      do_pulses(300);
      do_eoc(1'b0);
      chk("R4 saturated", int'(code_o), 255);
      do_start(6, 1'b0);
      chk("R1 cleared from saturation", int'(ovf_o), 0);
      do_pulses(3);
      do_eoc(1'b0);
      chk("R5 mode 6 fine", int'(code_o), 3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule